// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block is a purely combinational 16-bit binary adder. It takes two unsigned operands and a carry-in and returns a 16-bit sum and a carry-out. It is meant for datapaths where the carry chain must be short. No carry passes from one bit to the next in sequence.

The operands are split into four 4-bit groups. Each bit produces a generate term and a propagate term. Each group resolves all of its internal carries at once from flattened sum-of-products equations. Each group also reports one group generate and one group propagate. A second lookahead tier applies the same equation form to those group terms. It produces the carry into each upper group and the final carry-out, so no carry ripples between groups either.

Top module: `lookahead_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + c_i`, with all three read as unsigned values.
- R2: `c_o` equals bit 16 of the unsigned sum `a_i + b_i + c_i`.
- R3: Bit `k` generates when `a_i[k] & b_i[k]` is 1. Bit `k` propagates when `a_i[k] ^ b_i[k]` is 1. No bit does both. When every bit propagates (`b_i == ~a_i`), `c_o` equals `c_i` and every bit of `sum_o` equals `~c_i`.
- R4: When `a_i[15]` and `b_i[15]` are both 1, `c_o` is 1 for any value of the other inputs.
- R5: The carry into each 4-bit group (groups 1 to 3, plus the carry-out) equals that group's lower neighbour's group generate, OR its group propagate AND the carry into that neighbour. A carry is therefore correct across every group boundary (bits 3→4, 7→8, 11→12).
- R6: Inside a group, each carry into bits 1 to 3 equals `g | (p & c)` of the bit below it. These carries come from the flattened equations and not from a chain.
- R7: A group's propagate is 1 only when all four of its bits propagate. A group's generate and propagate are never 1 together. The group's carry-out equals `gen | (prop & group carry-in)`.
- R8: The outputs depend only on the present inputs. They follow a change of the inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| c_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| c_o | output | 1 | Carry out of bit 15 |

## Verification
The immediate assertions check on every input change that:
- bits never generate and propagate together;
- each flattened carry agrees with the one-step carry relation, both inside a group and across the second tier;
- group generate and propagate explain each group's carry-out;
- the sum and carry-out match the arithmetic sum.

Only the bench scenarios can show the boundary behaviours as observed at the ports: full-length propagation under both carry-in values, carries crossing each group boundary, and the forced carry-out from the top bit. They also show that the outputs settle with no clock.

// File: rtl/la_pkg.sv
package la_pkg;
  // Span of one lookahead unit; both tiers use the same span.
  parameter int unsigned LA_SPAN = 4;
  localparam int unsigned LA_TIERS_W = LA_SPAN * LA_SPAN;

  typedef logic [LA_SPAN-1:0] span_t;
  typedef logic [LA_SPAN:0]   span_c_t;

  // Flattened sum-of-products carries: c[k+1] = g[k] | p[k]g[k-1] | ... | p[k..0]cin
  function automatic span_c_t span_carries(span_t g, span_t p, logic cin);
    span_c_t c;
    c    = '0;
    c[0] = cin;
    for (int k = 0; k < int'(LA_SPAN); k++) begin
      logic acc;
      acc = 1'b0;
      for (int j = 0; j <= k; j++) begin
        logic term;
        term = g[j];
        for (int m = j + 1; m <= k; m++) term = term & p[m];
        acc = acc | term;
      end
      begin
        logic tail;
        tail = cin;
        for (int m = 0; m <= k; m++) tail = tail & p[m];
        acc = acc | tail;
      end
      c[k+1] = acc;
    end
    return c;
  endfunction

  function automatic logic span_gen(span_t g, span_t p);
    span_c_t c;
    c = span_carries(g, p, 1'b0);
    return c[LA_SPAN];
  endfunction

  function automatic logic span_prop(span_t p);
    return &p;
  endfunction
endpackage

// File: rtl/la_bit_pg.sv
module la_bit_pg #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] g_o,
  output logic [WIDTH-1:0] p_o
);
  for (genvar i = 0; i < int'(WIDTH); i++) begin : g_bit
    assign g_o[i] = a_i[i] & b_i[i];
    assign p_o[i] = a_i[i] ^ b_i[i];
  end

  always_comb begin
    for (int i = 0; i < int'(WIDTH); i++) begin
      assert_bit_exclusive_R3: assert (!(g_o[i] && p_o[i]))
        else $error("bit %0d both generates and propagates", i);
    end
  end
endmodule

// File: rtl/la_group.sv
module la_group
  import la_pkg::*;
(
  input  span_t g_i,
  input  span_t p_i,
  input  logic  cin_i,
  output span_t c_o,     // carries into each bit of the group, c_o[0] = cin_i
  output logic  gg_o,
  output logic  gp_o
);
  span_c_t full_c;

  assign full_c = span_carries(g_i, p_i, cin_i);
  assign c_o    = full_c[LA_SPAN-1:0];
  assign gg_o   = span_gen(g_i, p_i);
  assign gp_o   = span_prop(p_i);

  always_comb begin
    for (int k = 0; k < int'(LA_SPAN); k++) begin
      assert_group_step_R6: assert (full_c[k+1] == (g_i[k] | (p_i[k] & full_c[k])))
        else $error("group carry %0d breaks one-step relation", k + 1);
    end
    assert_group_excl_R7: assert (!(gg_o && gp_o))
      else $error("group generate and propagate both set");
    assert_group_out_R7: assert (full_c[LA_SPAN] == (gg_o | (gp_o & cin_i)))
      else $error("group G/P disagree with group carry-out");
  end
endmodule

// File: rtl/la_tier2.sv
module la_tier2
  import la_pkg::*;
(
  input  span_t   gg_i,
  input  span_t   gp_i,
  input  logic    cin_i,
  output span_c_t gc_o     // gc_o[j] = carry into group j, gc_o[LA_SPAN] = carry-out
);
  assign gc_o = span_carries(gg_i, gp_i, cin_i);

  always_comb begin
    for (int j = 0; j < int'(LA_SPAN); j++) begin
      assert_tier_step_R5: assert (gc_o[j+1] == (gg_i[j] | (gp_i[j] & gc_o[j])))
        else $error("group carry %0d breaks second-tier relation", j + 1);
    end
  end
endmodule

// File: rtl/lookahead_adder.sv
module lookahead_adder
  import la_pkg::*;
(
  input  logic [15:0] a_i,
  input  logic [15:0] b_i,
  input  logic        c_i,
  output logic [15:0] sum_o,
  output logic        c_o
);
  localparam int unsigned SPAN   = LA_SPAN;
  localparam int unsigned NGRP   = LA_SPAN;
  localparam int unsigned WIDTH  = SPAN * NGRP;

  logic [WIDTH-1:0] bit_g, bit_p, bit_c;
  span_t            grp_g, grp_p;
  span_c_t          grp_c;

  la_bit_pg #(.WIDTH(WIDTH)) u_pg (
    .a_i (a_i),
    .b_i (b_i),
    .g_o (bit_g),
    .p_o (bit_p)
  );

  for (genvar j = 0; j < int'(NGRP); j++) begin : g_grp
    la_group u_grp (
      .g_i   (bit_g[j*SPAN +: SPAN]),
      .p_i   (bit_p[j*SPAN +: SPAN]),
      .cin_i (grp_c[j]),
      .c_o   (bit_c[j*SPAN +: SPAN]),
      .gg_o  (grp_g[j]),
      .gp_o  (grp_p[j])
    );
  end

  la_tier2 u_tier2 (
    .gg_i  (grp_g),
    .gp_i  (grp_p),
    .cin_i (c_i),
    .gc_o  (grp_c)
  );

  assign sum_o = bit_p ^ bit_c;
  assign c_o   = grp_c[NGRP];

  always_comb begin
    assert_sum_R1: assert ({c_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {16'd0, c_i}))
      else $error("sum/carry disagree with arithmetic");
    assert_top_gen_R4: assert (!(a_i[15] && b_i[15]) || c_o)
      else $error("top-bit generate did not force carry-out");
    assert_all_prop_R3: assert (!(&bit_p) || (c_o == c_i))
      else $error("full propagate did not pass carry-in");
  end
endmodule

// File: tb/lookahead_adder_bench.sv
module lookahead_adder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a, b;
  logic        cin;
  logic [15:0] sum;
  logic        cout;
  int          total = 0;
  int          bad   = 0;
  bit          done  = 1'b0;

  always #2 clk = ~clk;   // 4 ns period

  lookahead_adder u_lookahead_adder (
    .a_i   (a),
    .b_i   (b),
    .c_i   (cin),
    .sum_o (sum),
    .c_o   (cout)
  );

  // Behavioural model: plain integer addition.
  task automatic run(input logic [15:0] x, input logic [15:0] y, input logic ci, input string req);
    int exp_v;
    @(negedge clk);
    a = x; b = y; cin = ci;
    #1;
    exp_v = int'(x) + int'(y) + int'(ci);
    total++;
    if (sum !== exp_v[15:0] || cout !== exp_v[16]) begin
      bad++;
      $display("FAIL %s: a=%h b=%h cin=%0b got {%0b,%h} expected {%0b,%h}",
               req, x, y, ci, cout, sum, exp_v[16], exp_v[15:0]);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    run(16'h0000, 16'h0000, 1'b0, "R1 zero");
    run(16'h0000, 16'h0000, 1'b1, "R1 cin only");
    run(16'hFFFF, 16'hFFFF, 1'b0, "R2 all ones");
    run(16'hFFFF, 16'hFFFF, 1'b1, "R2 all ones cin");
    run(16'hAAAA, 16'h5555, 1'b0, "R3 full propagate cin0");
    run(16'hAAAA, 16'h5555, 1'b1, "R3 full propagate cin1");
    run(16'h1234, 16'hEDCB, 1'b1, "R3 complement pair");
    run(16'h8000, 16'h8000, 1'b0, "R4 top generate");
    run(16'h8001, 16'hC000, 1'b1, "R4 top generate cin");
    run(16'h000F, 16'h0001, 1'b0, "R5 boundary 3-4");
    run(16'h00FF, 16'h0000, 1'b1, "R5 boundary 7-8");
    run(16'h0FFF, 16'h0001, 1'b0, "R5 boundary 11-12");
    run(16'hFFFF, 16'h0000, 1'b1, "R5 chain to carry-out");
    run(16'h0007, 16'h0000, 1'b1, "R6 in-group bits 0-3");
    run(16'h0001, 16'h0001, 1'b0, "R6 in-group generate");
    run(16'h0F0F, 16'h00F1, 1'b0, "R7 group generate");
    run(16'h0F00, 16'h00FF, 1'b1, "R7 group propagate");
    for (int i = 0; i < 2000; i++)
      run(16'($urandom), 16'($urandom), 1'($urandom), "R1 R2 random");
    // R8: outputs follow a change with no clock edge between
    @(negedge clk);
    a = 16'h7FFF; b = 16'h0001; cin = 1'b0;
    #0.5;
    a = 16'h0100; b = 16'h0200;
    #0.5;
    total++;
    if (sum !== 16'h0300 || cout !== 1'b0) begin
      bad++;
      $display("FAIL R8: got {%0b,%h} expected {0,0300}", cout, sum);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule